// File: doc/BRIEF.md
# Guest Entry Precondition Gate

This block decides, in one clock, what happens to a request to enter a guest context. The request may be a launch or a resume. The gate evaluates the processor mode, the privilege level and the state of the selected control structure in a fixed priority order. It then reports exactly one of five outcomes: an undefined-opcode fault, a general-protection fault, a fail-invalid result (carry flag), a fail-valid result (zero flag plus an error number), or permission to proceed to the later field-consistency checks.

The gate keeps one launch-state bit for each control structure. A launch that passes sets the selected structure's bit to launched. A separate clear command returns any structure's bit to clear. A launch needs the bit to be clear, and a resume needs it to be launched. The last fail-valid error number is held in a 32-bit register. Only a later fail-valid result overwrites it.

All results are registered. A request sampled at a rising edge is answered on the outputs for exactly the cycle that follows.

Top module: `vm_entry_gate`

## Requirements
- R1: When a request is sampled with `mode_v86` or `mode_compat` high, the next cycle shows `res_ud` alone, whatever the other inputs are.
- R2: Otherwise, a request with `cpl` not equal to 0 gives `res_gp`.
- R3: Otherwise, a request with `ctx_valid` low gives `res_fail_inv` with `flag_cf`=1 and `flag_zf`=0.
- R4: Otherwise, a request with `ctx_shadow` high gives `res_fail_inv` with `flag_cf`=1 and `flag_zf`=0.
- R5: Otherwise, a request with `ss_block` high gives `res_fail_val` with `flag_zf`=1, and `err_code` becomes 26.
- R6: Otherwise, a launch (`req_resume`=0) whose selected structure is already launched gives `res_fail_val`, `flag_zf`=1 and `err_code`=4.
- R7: Otherwise, a resume (`req_resume`=1) whose selected structure is clear gives `res_fail_val`, `flag_zf`=1 and `err_code`=5.
- R8: When all preconditions pass, the result is `res_proceed` with both flags low. A passing launch marks structure `ctx_sel` as launched. A passing resume leaves that structure's state alone.
- R9: A `clr_valid` pulse returns structure `clr_sel` to clear. If a clear and a passing launch hit the same structure in the same cycle, the structure ends up launched.
- R10: Each request yields exactly one result output, high for exactly the next cycle. With no request, all result and flag outputs are low.
- R11: `err_code` changes only on a fail-valid result. Fault, fail-invalid, proceed and idle cycles leave it unchanged.
- R12: After reset every structure is clear, `err_code` is 0, and all result and flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Entry request this cycle |
| req_resume | input | 1 | 0 = launch, 1 = resume |
| mode_v86 | input | 1 | Processor in virtual-8086 mode |
| mode_compat | input | 1 | Processor in compatibility mode |
| cpl | input | 2 | Current privilege level |
| ctx_valid | input | 1 | A current control structure exists |
| ctx_shadow | input | 1 | Current structure is a shadow copy |
| ctx_sel | input | SEL_W | Index of the current structure |
| ss_block | input | 1 | Stack-segment-load blocking active |
| clr_valid | input | 1 | Clear launch state of one structure |
| clr_sel | input | SEL_W | Structure index to clear |
| res_ud | output | 1 | Undefined-opcode fault result |
| res_gp | output | 1 | General-protection fault result |
| res_fail_inv | output | 1 | Fail-invalid result |
| res_fail_val | output | 1 | Fail-valid result |
| res_proceed | output | 1 | Preconditions passed |
| flag_cf | output | 1 | Carry flag value to report |
| flag_zf | output | 1 | Zero flag value to report |
| err_code | output | ERR_W | Last fail-valid error number |

## Verification
The embedded assertions check, on every cycle, the timing and exclusivity of the result pulses, the precedence of the two faults, fail-invalid and stack-segment blocking over the lower checks, and that the flags stay low on proceed. They also check that the error register holds except on fail-valid. The launch-state gating (R6, R7) depends on earlier launches and clears, so only the bench's scenarios can show it. The same applies to the clear-versus-launch collision of R9. The bench tracks each structure's state in its reference model and compares every output on every clock.

// File: rtl/vm_entry_gate.sv
module vm_entry_gate #(
  parameter int NUM_CTX = 4,
  parameter int ERR_W = 32,
  parameter int ERR_SS_BLOCK = 26,
  parameter int ERR_LAUNCH_DIRTY = 4,
  parameter int ERR_RESUME_CLEAN = 5,
  localparam int SEL_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_resume,
  input  logic             mode_v86,
  input  logic             mode_compat,
  input  logic [1:0]       cpl,
  input  logic             ctx_valid,
  input  logic             ctx_shadow,
  input  logic [SEL_W-1:0] ctx_sel,
  input  logic             ss_block,
  input  logic             clr_valid,
  input  logic [SEL_W-1:0] clr_sel,
  output logic             res_ud,
  output logic             res_gp,
  output logic             res_fail_inv,
  output logic             res_fail_val,
  output logic             res_proceed,
  output logic             flag_cf,
  output logic             flag_zf,
  output logic [ERR_W-1:0] err_code
);

  typedef enum logic [2:0] {V_UD, V_GP, V_FINV, V_FVAL, V_GO} verdict_t;

  logic [NUM_CTX-1:0] launched_q;
  logic               armed_q;
  verdict_t           verdict;
  logic [ERR_W-1:0]   verdict_err;
  logic               sel_launched;
  logic               go_launch;

  assign sel_launched = launched_q[ctx_sel];
  assign go_launch    = req_valid && (verdict == V_GO) && !req_resume;

  always_comb begin
    verdict     = V_GO;
    verdict_err = '0;
    if (mode_v86 || mode_compat)        verdict = V_UD;
    else if (cpl != 2'd0)               verdict = V_GP;
    else if (!ctx_valid || ctx_shadow)  verdict = V_FINV;
    else if (ss_block) begin
      verdict     = V_FVAL;
      verdict_err = ERR_W'(ERR_SS_BLOCK);
    end else if (!req_resume && sel_launched) begin
      verdict     = V_FVAL;
      verdict_err = ERR_W'(ERR_LAUNCH_DIRTY);
    end else if (req_resume && !sel_launched) begin
      verdict     = V_FVAL;
      verdict_err = ERR_W'(ERR_RESUME_CLEAN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ud       <= 1'b0;
      res_gp       <= 1'b0;
      res_fail_inv <= 1'b0;
      res_fail_val <= 1'b0;
      res_proceed  <= 1'b0;
      flag_cf      <= 1'b0;
      flag_zf      <= 1'b0;
      err_code     <= '0;
      armed_q      <= 1'b0;
    end else begin
      armed_q      <= 1'b1;
      res_ud       <= req_valid && (verdict == V_UD);
      res_gp       <= req_valid && (verdict == V_GP);
      res_fail_inv <= req_valid && (verdict == V_FINV);
      res_fail_val <= req_valid && (verdict == V_FVAL);
      res_proceed  <= req_valid && (verdict == V_GO);
      flag_cf      <= req_valid && (verdict == V_FINV);
      flag_zf      <= req_valid && (verdict == V_FVAL);
      if (req_valid && verdict == V_FVAL) err_code <= verdict_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launched_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CTX; i++) begin
        if (go_launch && ctx_sel == SEL_W'(i))        launched_q[i] <= 1'b1;
        else if (clr_valid && clr_sel == SEL_W'(i))   launched_q[i] <= 1'b0;
      end
    end
  end

  assert_result_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_ud, res_gp, res_fail_inv, res_fail_val, res_proceed}));

  assert_result_per_request_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(req_valid) |-> $countones({res_ud, res_gp, res_fail_inv, res_fail_val, res_proceed}) == 1);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !$past(req_valid) |-> !(res_ud || res_gp || res_fail_inv || res_fail_val || res_proceed || flag_cf || flag_zf));

  assert_mode_fault_first_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(req_valid && (mode_v86 || mode_compat)) |-> res_ud);

  assert_priv_fault_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(req_valid && !mode_v86 && !mode_compat && cpl != 2'd0) |-> res_gp);

  assert_no_struct_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(req_valid && !mode_v86 && !mode_compat && cpl == 2'd0 && !ctx_valid) |-> (res_fail_inv && flag_cf && !flag_zf));

  assert_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(req_valid && !mode_v86 && !mode_compat && cpl == 2'd0 && ctx_valid && ctx_shadow) |-> (res_fail_inv && flag_cf));

  assert_ss_block_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(req_valid && !mode_v86 && !mode_compat && cpl == 2'd0 && ctx_valid && !ctx_shadow && ss_block)
      |-> (res_fail_val && flag_zf && err_code == ERR_W'(ERR_SS_BLOCK)));

  assert_proceed_flags_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_proceed || res_ud || res_gp) |-> (!flag_cf && !flag_zf));

  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !res_fail_val |-> $stable(err_code));

endmodule

// File: tb/tb_vm_entry_gate.sv
module tb_vm_entry_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTX = 4;
  localparam int SEL_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_resume = 0, mode_v86 = 0, mode_compat = 0;
  logic [1:0] cpl = 0;
  logic ctx_valid = 0, ctx_shadow = 0, ss_block = 0, clr_valid = 0;
  logic [SEL_W-1:0] ctx_sel = 0, clr_sel = 0;
  logic res_ud, res_gp, res_fail_inv, res_fail_val, res_proceed, flag_cf, flag_zf;
  logic [31:0] err_code;

  int checks = 0;
  int fails = 0;
  bit ref_launched [NUM_CTX];
  int ref_err = 0;
  logic [6:0] exp_vec = '0;
  string exp_tag = "R12";

  vm_entry_gate #(.NUM_CTX(NUM_CTX)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input bit rq, input bit rs, input bit v8, input bit cm, input int pl,
                       input bit cv, input bit sh, input int sel, input bit ssb,
                       input bit cl, input int csel);
    req_valid = rq; req_resume = rs; mode_v86 = v8; mode_compat = cm; cpl = 2'(pl);
    ctx_valid = cv; ctx_shadow = sh; ctx_sel = SEL_W'(sel); ss_block = ssb;
    clr_valid = cl; clr_sel = SEL_W'(csel);
  endtask

  task automatic model_edge();
    bit launched;
    launched = ref_launched[ctx_sel];
    exp_vec = '0;
    if (!req_valid) exp_tag = "R10";
    else if (mode_v86 || mode_compat) begin exp_vec = 7'b1000000; exp_tag = "R1"; end
    else if (cpl != 0) begin exp_vec = 7'b0100000; exp_tag = "R2"; end
    else if (!ctx_valid) begin exp_vec = 7'b0010010; exp_tag = "R3"; end
    else if (ctx_shadow) begin exp_vec = 7'b0010010; exp_tag = "R4"; end
    else if (ss_block) begin exp_vec = 7'b0001001; ref_err = 26; exp_tag = "R5"; end
    else if (!req_resume && launched) begin exp_vec = 7'b0001001; ref_err = 4; exp_tag = "R6"; end
    else if (req_resume && !launched) begin exp_vec = 7'b0001001; ref_err = 5; exp_tag = "R7"; end
    else begin exp_vec = 7'b0000100; exp_tag = "R8"; end
    if (clr_valid) ref_launched[clr_sel] = 0;
    if (exp_tag == "R8" && !req_resume) ref_launched[ctx_sel] = 1;
  endtask

  task automatic compare(input string tag);
    logic [6:0] got;
    string t;
    got = {res_ud, res_gp, res_fail_inv, res_fail_val, res_proceed, flag_cf, flag_zf};
    t = (tag != "") ? tag : exp_tag;
    checks++;
    if (got !== exp_vec || err_code !== 32'(ref_err)) begin
      fails++;
      $display("FAIL %s: outputs %b err %0d, expected %b err %0d", t, got, err_code, exp_vec, ref_err);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_CTX; i++) ref_launched[i] = 0;
    repeat (3) @(negedge clk);
    compare("R12");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R12");

    drive(1,0,0,0,0,1,0,0,0,0,0); step("R8");
    drive(1,0,0,0,0,1,0,0,0,0,0); step("R6");
    drive(1,1,0,0,0,1,0,0,0,0,0); step("R8");
    drive(1,1,0,0,0,1,0,1,0,0,0); step("R7");
    drive(1,0,0,0,3,0,1,1,1,0,0); step("R2");
    drive(1,0,1,1,3,0,1,1,1,0,0); step("R1");
    drive(1,0,0,0,0,0,0,0,0,0,0); step("R3");
    drive(1,0,0,0,0,1,1,0,0,0,0); step("R4");
    drive(0,0,0,0,0,0,0,0,0,0,0); step("R11");
    drive(1,0,0,0,0,1,0,0,1,0,0); step("R5");
    drive(0,0,0,0,0,0,0,0,0,1,0); step("R9");
    drive(1,0,0,0,0,1,0,0,0,0,0); step("R9");
    drive(1,0,0,0,0,1,0,2,0,1,2); step("R9");
    drive(1,0,0,0,0,1,0,2,0,0,0); step("R9");
    drive(1,1,0,0,0,1,0,2,0,0,0); step("R9");

    for (int n = 0; n < 3000; n++) begin
      drive($urandom_range(0,3) != 0, $urandom_range(0,1),
            $urandom_range(0,15) == 0, $urandom_range(0,15) == 0,
            ($urandom_range(0,7) == 0) ? $urandom_range(1,3) : 0,
            $urandom_range(0,9) != 0, $urandom_range(0,9) == 0,
            $urandom_range(0,NUM_CTX-1), $urandom_range(0,7) == 0,
            $urandom_range(0,3) == 0, $urandom_range(0,NUM_CTX-1));
      step("");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule